// File: doc/BRIEF.md
# Serial Control Slave with Read-Data Interrupt

This block is the device side of a four-wire serial control port. A host lowers chip select, sends a 7-bit device address and a direction bit, then moves whole bytes in either direction. Write bytes are handed to the core as single-cycle strobes. Read bytes are taken from the head of an outbound first-word-fall-through queue that the core fills.

An active-low interrupt line tells the host that outbound bytes are waiting. During a read, the line is released at a fixed bit of the byte in flight if the queue has run dry. It then stays released until the next serial clock rising edge. From that point the current transaction returns only zero bytes. To collect data that arrives later, the host has to open a new read transaction.

The serial pins are brought into the system clock domain through synchronizer chains. Every serial event is therefore acted on a fixed number of system clock cycles after the pin changes. The serial clock must be slow enough relative to `clk_i` for each of its edges to be seen.

Top module: `spi_ctl_slave`

## Requirements
- R1: A falling chip select opens a transaction. The first 8 bits sampled on serial clock rising edges are the device address (7 bits, MSB first) followed by a direction bit, where 1 selects read and 0 selects write.
- R2: If the address does not equal the parameter DEV_ADDR, the rest of the transaction has no effect. No write strobe is produced, nothing is popped, and the data output stays disabled.
- R3: In a write transaction, every group of 8 bits after the header (MSB first) produces one `wr_valid_o` pulse, one clock long, carrying that byte. A partial byte cut off by chip select rising is dropped.
- R4: `sdo_oe_o` is 0 whenever chip select is high. It is also 0 during the header and throughout write or ignored transactions.
- R5: In a read transaction, `sdo_o` updates after each serial clock falling edge, so that it is stable at the next rising edge. Each byte is sent MSB first, and the first byte's MSB is presented after the falling edge that follows the direction bit.
- R6: Each read byte is taken from `rd_data_i` on the rising edge of the last bit of the preceding byte (the direction bit for the first byte). A byte taken from the queue raises `rd_pop_o` for exactly one clock.
- R7: If the queue is empty when a byte is taken, that byte is 0x00 and there is no pop.
- R8: Outside a release hold, `irq_no` is low when the queue holds data and high when it is empty.
- R9: During a read, if the queue is empty at the rising edge of bit 6 of the current byte (the second-to-last bit, counting from 0 at the MSB), `irq_no` goes high. It stays high until the next serial clock rising edge, even if data arrives in between.
- R10: After such a release, every further byte of the same transaction is 0x00 and nothing is popped. The next read transaction fetches the waiting data normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host (valid when enabled) |
| sdo_oe_o | output | 1 | Output enable for the tri-state data pad |
| irq_no | output | 1 | Interrupt request, active low, open-drain drive level |
| wr_valid_o | output | 1 | Write byte strobe |
| wr_data_o | output | DATA_W | Received write byte |
| rd_valid_i | input | 1 | Outbound queue not empty |
| rd_data_i | input | DATA_W | Head of outbound queue |
| rd_pop_o | output | 1 | Consume the queue head |

## Verification
The bench uses DEV_ADDR 7'h35, DATA_W 8 and two synchronizer stages, with eight system clocks per serial clock phase. This leaves room inside a single high phase to push a byte into the queue after the bit-6 release and before the bit-7 edge, which is the window in which the hold and drain rules can be observed. Address mismatches are produced by flipping one address bit against DEV_ADDR, and random byte counts take reads past the end of the queue.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HDR   = 3'd1,
    PH_WRITE = 3'd2,
    PH_READ  = 3'd3,
    PH_SKIP  = 3'd4
  } phase_e;
endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RST_VAL;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_ctl_edge.sv
module spi_ctl_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/spi_ctl_frame.sv
module spi_ctl_frame
  import spi_ctl_pkg::*;
#(
  parameter int DATA_W             = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_s_i,
  input  logic              drained_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output phase_e            phase_o,
  output logic [$clog2(DATA_W)-1:0] bit_cnt_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_pop_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W-1);

  phase_e            phase_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] rx_sr_q, tx_byte_q;
  logic              cs_prev_q, sdo_q;
  logic [DATA_W-1:0] rx_next;
  logic              cs_fall;

  assign rx_next = {rx_sr_q[DATA_W-2:0], sdi_s_i};
  assign cs_fall = cs_prev_q & ~cs_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      bit_cnt_q  <= '0;
      rx_sr_q    <= '0;
      tx_byte_q  <= '0;
      cs_prev_q  <= 1'b1;
      sdo_q      <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      rd_pop_o   <= 1'b0;
    end else begin
      cs_prev_q  <= cs_s_i;
      wr_valid_o <= 1'b0;
      rd_pop_o   <= 1'b0;
      if (cs_s_i) begin
        phase_q <= PH_IDLE;
      end else if (cs_fall) begin
        phase_q   <= PH_HDR;
        bit_cnt_q <= '0;
      end else if (sclk_rise_i) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (phase_q != PH_READ) rx_sr_q <= rx_next;
        if (bit_cnt_q == LAST) begin
          bit_cnt_q <= '0;
          unique case (phase_q)
            PH_HDR: begin
              if (rx_sr_q[DATA_W-2:0] != DEV_ADDR) phase_q <= PH_SKIP;
              else if (sdi_s_i) phase_q <= PH_READ;
              else phase_q <= PH_WRITE;
            end
            PH_WRITE: begin
              wr_valid_o <= 1'b1;
              wr_data_o  <= rx_next;
            end
            default: ;
          endcase
          // fetch next outbound byte: after header read bit or at end of each read byte
          if ((phase_q == PH_HDR && rx_sr_q[DATA_W-2:0] == DEV_ADDR && sdi_s_i)
              || phase_q == PH_READ) begin
            if (rd_valid_i && !drained_i) begin
              tx_byte_q <= rd_data_i;
              rd_pop_o  <= 1'b1;
            end else begin
              tx_byte_q <= '0;
            end
          end
        end
      end else if (sclk_fall_i && phase_q == PH_READ) begin
        sdo_q <= tx_byte_q[LAST - bit_cnt_q];
      end
    end
  end

  assign phase_o   = phase_q;
  assign bit_cnt_o = bit_cnt_q;
  assign sdo_oe_o  = (phase_q == PH_READ);
  assign sdo_o     = sdo_oe_o ? sdo_q : 1'b0;
endmodule

// File: rtl/spi_ctl_irq.sv
module spi_ctl_irq #(
  parameter int DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_read_i,
  input  logic sclk_rise_i,
  input  logic [$clog2(DATA_W)-1:0] bit_cnt_i,
  input  logic rd_valid_i,
  output logic irq_no,
  output logic drained_o
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] REL_BIT = BIT_W'(DATA_W-2);

  logic hold_q, drained_q, irq_n_q;
  logic release_now, hold_next;

  assign release_now = in_read_i & sclk_rise_i & (bit_cnt_i == REL_BIT) & ~rd_valid_i;
  assign hold_next   = release_now | (hold_q & ~sclk_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= 1'b0;
      drained_q <= 1'b0;
      irq_n_q   <= 1'b1;
    end else begin
      hold_q  <= hold_next;
      irq_n_q <= hold_next | ~rd_valid_i;
      if (!in_read_i) drained_q <= 1'b0;
      else if (release_now) drained_q <= 1'b1;
    end
  end

  assign irq_no    = irq_n_q;
  assign drained_o = drained_q;
endmodule

// File: rtl/spi_ctl_slave.sv
module spi_ctl_slave
  import spi_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'h35
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              irq_no,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_pop_o
);
  localparam int BIT_W = $clog2(DATA_W);

  logic cs_s, sclk_s, sdi_s;
  logic sclk_rise, sclk_fall;
  logic drained, in_read;
  phase_e phase;
  logic [BIT_W-1:0] bit_cnt;

  spi_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_s));
  spi_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));
  spi_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdi_i), .q_o(sdi_s));

  spi_ctl_edge u_sclk_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sclk_s),
    .rise_o(sclk_rise), .fall_o(sclk_fall));

  spi_ctl_frame #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_s_i(cs_s),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .sdi_s_i(sdi_s),
    .drained_i(drained), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .phase_o(phase), .bit_cnt_o(bit_cnt),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .rd_pop_o(rd_pop_o),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

  assign in_read = (phase == PH_READ);

  spi_ctl_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_read_i(in_read),
    .sclk_rise_i(sclk_rise), .bit_cnt_i(bit_cnt), .rd_valid_i(rd_valid_i),
    .irq_no(irq_no), .drained_o(drained));
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk #(
  parameter int DATA_W = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic sclk_rise,
  input logic in_read,
  input logic skip,
  input logic [$clog2(DATA_W)-1:0] bit_cnt,
  input logic rd_valid_i,
  input logic rd_pop_o,
  input logic drained,
  input logic wr_valid_o,
  input logic sdo_oe_o,
  input logic irq_no
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] REL_BIT = BIT_W'(DATA_W-2);

  // R4
  a_r4_hiz_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s && $past(cs_s) |-> !sdo_oe_o);
  // R2
  a_r2_skip_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip && $past(skip) |-> !wr_valid_o && !rd_pop_o && !sdo_oe_o);
  // R3
  a_r3_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
  // R6
  a_r6_pop_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop_o |-> $past(rd_valid_i));
  // R9
  a_r9_release_bit6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_read && sclk_rise && bit_cnt == REL_BIT && !rd_valid_i |=> irq_no);
  // R10
  a_r10_no_pop_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop_o |-> !$past(drained));
endmodule

bind spi_ctl_slave spi_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .sclk_rise(sclk_rise),
  .in_read(in_read), .skip(phase == spi_ctl_pkg::PH_SKIP), .bit_cnt(bit_cnt),
  .rd_valid_i(rd_valid_i), .rd_pop_o(rd_pop_o), .drained(drained),
  .wr_valid_o(wr_valid_o), .sdo_oe_o(sdo_oe_o), .irq_no(irq_no));

// File: tb/sim_spi_ctl_slave.sv
`timescale 1ns/1ps
module sim_spi_ctl_slave;
  localparam int HALF = 8;
  localparam logic [6:0] DEV = 7'h35;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, irq_n, wr_valid, rd_pop;
  logic [7:0] wr_data;
  logic rd_valid;
  logic [7:0] rd_data;

  logic [7:0] qmem [0:63];
  int wr_ptr = 0, rd_ptr = 0;
  logic [7:0] wr_log [0:63];
  int wr_cnt = 0, oe_cnt = 0;
  bit [7:0] irq_seen;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rd_valid = (rd_ptr != wr_ptr);
  assign rd_data  = qmem[rd_ptr[5:0]];

  spi_ctl_slave #(.DATA_W(8), .SYNC_STAGES(2), .DEV_ADDR(DEV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_no(irq_n),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .rd_pop_o(rd_pop));

  always @(posedge clk) begin
    if (rd_pop && rd_valid) rd_ptr <= rd_ptr + 1;
    if (wr_valid) begin
      wr_log[wr_cnt[5:0]] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (sdo_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    qmem[wr_ptr[5:0]] = d;
    wr_ptr = wr_ptr + 1;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one byte each way; optional push half way through the high phase of bit 6
  task automatic xfer(input logic [7:0] tx, input bit push6, input logic [7:0] pd,
                      output logic [7:0] rx);
    for (int k = 0; k < 8; k++) begin
      sdi = tx[7-k];
      wait_clk(HALF);
      rx[7-k] = sdo;
      sclk = 1'b1;
      wait_clk(HALF/2);
      if (push6 && k == 6) push(pd);
      wait_clk(HALF/2);
      irq_seen[k] = irq_n;
      sclk = 1'b0;
    end
  endtask

  task automatic open_txn(input logic [6:0] a, input bit rd);
    logic [7:0] dummy;
    cs_n = 1'b0;
    wait_clk(HALF);
    xfer({a, rd}, 1'b0, 8'h00, dummy);
  endtask

  task automatic close_txn();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4*HALF);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    logic [7:0] rx, b;
    int base, n, p0, oe0;
    void'($urandom(32'd4711));
    wait_clk(5);
    // reset state: empty queue -> irq released, outputs quiet
    check(irq_n === 1'b1, "R8 reset irq", irq_n, 1);
    check(sdo_oe === 1'b0, "R4 reset oe", sdo_oe, 0);
    check(wr_valid === 1'b0 && rd_pop === 1'b0, "R3 reset strobes", {wr_valid, rd_pop}, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // R1/R3: random writes
    for (int it = 0; it < 6; it++) begin
      logic [7:0] sent [0:3];
      n = 1 + int'($urandom % 4);
      base = wr_cnt; oe0 = oe_cnt;
      open_txn(DEV, 1'b0);
      for (int j = 0; j < n; j++) begin
        sent[j] = 8'($urandom);
        xfer(sent[j], 1'b0, 8'h00, rx);
      end
      close_txn();
      check(wr_cnt == base + n, "R1 write byte count", wr_cnt - base, n);
      for (int j = 0; j < n; j++)
        check(wr_log[(base + j) % 64] == sent[j], "R3 write data", wr_log[(base + j) % 64], sent[j]);
      check(oe_cnt == oe0, "R4 oe during write", oe_cnt - oe0, 0);
    end

    // R3: partial byte dropped
    base = wr_cnt;
    open_txn(DEV, 1'b0);
    xfer(8'hC3, 1'b0, 8'h00, rx);
    for (int k = 0; k < 4; k++) begin
      sdi = k[0]; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    close_txn();
    check(wr_cnt == base + 1, "R3 partial byte dropped", wr_cnt - base, 1);
    check(wr_log[base % 64] == 8'hC3, "R3 full byte kept", wr_log[base % 64], 8'hC3);

    // R2: wrong address, write and read
    push(8'h5A);
    wait_clk(4);
    check(irq_n === 1'b0, "R8 irq low with data", irq_n, 0);
    base = wr_cnt; oe0 = oe_cnt; p0 = rd_ptr;
    open_txn(DEV ^ 7'h01, 1'b0);
    xfer(8'hFF, 1'b0, 8'h00, rx);
    close_txn();
    open_txn(DEV ^ 7'h40, 1'b1);
    xfer(8'h00, 1'b0, 8'h00, rx);
    xfer(8'h00, 1'b0, 8'h00, rx);
    close_txn();
    check(wr_cnt == base, "R2 no write on mismatch", wr_cnt - base, 0);
    check(rd_ptr == p0, "R2 no pop on mismatch", rd_ptr - p0, 0);
    check(oe_cnt == oe0, "R2 output stays disabled", oe_cnt - oe0, 0);

    // R5/R6/R7: random reads running past the queue end
    for (int it = 0; it < 4; it++) begin
      int avail;
      n = int'($urandom % 3);
      for (int j = 0; j < n; j++) push(8'($urandom));
      wait_clk(2);
      p0 = rd_ptr; avail = wr_ptr - rd_ptr; oe0 = oe_cnt;
      open_txn(DEV, 1'b1);
      for (int j = 0; j < avail + 1; j++) begin
        xfer(8'h00, 1'b0, 8'h00, rx);
        b = (j < avail) ? qmem[(p0 + j) % 64] : 8'h00;
        check(rx == b, (j < avail) ? "R5 read data" : "R7 empty gives zero", rx, b);
      end
      close_txn();
      check(rd_ptr == p0 + avail, "R6 pop count", rd_ptr - p0, avail);
      check(oe_cnt > oe0, "R5 output enabled in read", oe_cnt - oe0, 1);
      check(sdo_oe === 1'b0, "R4 oe after close", sdo_oe, 0);
    end

    // R9/R10: release at bit 6, late arrival held off and not popped
    push(8'hA1); push(8'hB2);
    wait_clk(2);
    open_txn(DEV, 1'b1);
    xfer(8'h00, 1'b0, 8'h00, rx);
    check(rx == 8'hA1, "R6 first byte", rx, 8'hA1);
    xfer(8'h00, 1'b1, 8'hC3, rx);
    check(rx == 8'hB2, "R6 second byte", rx, 8'hB2);
    check(irq_seen[6] === 1'b1, "R9 held after late push", irq_seen[6], 1);
    check(irq_seen[7] === 1'b0, "R9 drops after next rise", irq_seen[7], 0);
    p0 = rd_ptr;
    xfer(8'h00, 1'b0, 8'h00, rx);
    check(rx == 8'h00, "R10 drained byte zero", rx, 0);
    check(rd_ptr == p0, "R10 no pop while drained", rd_ptr - p0, 0);
    close_txn();
    check(irq_n === 1'b0, "R8 irq low after close", irq_n, 0);
    open_txn(DEV, 1'b1);
    xfer(8'h00, 1'b0, 8'h00, rx);
    close_txn();
    check(rx == 8'hC3, "R10 new read fetches", rx, 8'hC3);
    check(irq_n === 1'b1, "R8 irq high when empty", irq_n, 1);

    summary();
  end
endmodule